// File: doc/BRIEF.md
# Smart-Card Character Error and Retry Controller

This block sits beside the character UART of a smart-card reader and decides what happens after each character is sent or received. It takes one result per received character (parity good or bad) and one result per transmitted character (acknowledged or refused by the card), and turns them into a sticky parity-error status bit, an active-low interrupt and, in the character-oriented protocol (T=0), a scheduled automatic resend of refused characters.

Software programs a 3-bit error budget through a write-only control register. In T=0 receive, the status bit is raised only once the number of consecutive bad characters reaches the budget plus one, and a good character starts the count again. In T=0 transmit, the same field sets how many times a refused character is resent. Each resend starts 15 ETU after the start bit of the refused character. With a budget of zero, resending is off, and the next character may start 13.5 ETU after the previous start bit. In the block-oriented protocol (T=1), the count is bypassed: the first bad character raises the status bit, and transmit refusals are not acted on. Timing is kept in half-ETU steps from a half-ETU tick input, so the 13.5 ETU point is exact.

Top module: `card_err_retry`

## Requirements
- R1: In T=0 (proto_t1=0), with the control field F in ctrl_wdata bits [2:0], the status bit is set by the (F+1)-th consecutive bad received character and not earlier; the receive count then restarts from zero.
- R2: In T=0, a received character with good parity clears the consecutive bad-character count, so F further bad characters after it do not set the status bit.
- R3: When the status bit is set, it appears as stat_rdata bit 0 and irq_n goes low in the cycle after the error event.
- R4: The status bit stays set through further good characters and acknowledged transmits until a stat_rd strobe; the strobe clears the bit and raises irq_n in the next cycle.
- R5: A stat_rd strobe in the same cycle as a new error event leaves the status bit set.
- R6: In T=1 (proto_t1=1), the first bad received character sets the status bit whatever F is, and a refused transmit (tx_done with tx_nak) neither schedules a resend nor sets the status bit.
- R7: In T=0 with F>0, each refused character is resent while fewer than F resends have been made for it; the next refusal after F resends sets the status bit and schedules nothing; an acknowledged transmit restores the full budget.
- R8: A scheduled resend is issued as a one-cycle retx_go pulse in the cycle after the 30th half_etu_tick that follows the last tx_sof (15 ETU), and never earlier.
- R9: In T=0 with F=0, the first refusal sets the status bit and schedules no resend; tx_ready is low from tx_sof until the 27th half_etu_tick after it (13.5 ETU) and high from the cycle after that tick.
- R10: After reset, the control field is 0, the status bit is clear, irq_n is high, tx_ready is high and retx_go is low.
- R11: Control bits [7:3] have no effect; stat_rdata bits [7:1] always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_etu_tick | input | 1 | One-cycle pulse every half ETU |
| proto_t1 | input | 1 | 0 = T=0 protocol, 1 = T=1 protocol |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data; bits [2:0] are the error budget F |
| stat_rd | input | 1 | Status register read strobe (clears the sticky bit) |
| stat_rdata | output | 8 | Status read data; bit 0 is the parity-error bit |
| rx_done | input | 1 | One-cycle pulse: a character has been received |
| rx_par_ok | input | 1 | Parity of the received character was good (valid with rx_done) |
| tx_sof | input | 1 | One-cycle pulse at the start bit of a transmitted character |
| tx_done | input | 1 | One-cycle pulse: result of the transmitted character is known |
| tx_nak | input | 1 | The card refused the character (valid with tx_done) |
| retx_go | output | 1 | One-cycle pulse: resend the last character now |
| tx_ready | output | 1 | A new character may be started |
| irq_n | output | 1 | Active-low interrupt, low while the status bit is set |

## Verification
The bench uses the default parameters: a 3-bit budget, 27 half-ETU for the next-character point and 30 half-ETU for the resend point. The 3-bit field reaches both ends of the budget, so the single-error case (F=0) and the eight-error case (F=7) are both tested. The half-ETU windows are short enough that the bench can count every tick and check that retx_go and tx_ready change at exactly the 30th and 27th tick and not one tick earlier.

// File: rtl/cer_pkg.sv
package cer_pkg;

    localparam int CER_REG_W      = 8;   // register data width
    localparam int CER_ECNT_W     = 3;   // error budget field width
    localparam int CER_GUARD_HALF = 27;  // 13.5 ETU in half-ETU steps
    localparam int CER_RETX_HALF  = 30;  // 15 ETU in half-ETU steps

    // Result of one character, as seen by the error logic
    typedef struct packed {
        logic done;
        logic bad;
    } char_ev_t;

    typedef enum logic {
        PROTO_T0 = 1'b0,
        PROTO_T1 = 1'b1
    } proto_e;

    // True while a further resend is still allowed
    function automatic logic budget_left(input logic [CER_ECNT_W-1:0] used,
                                         input logic [CER_ECNT_W-1:0] field);
        return used < field;
    endfunction

endpackage

// File: rtl/cer_rx_count.sv
module cer_rx_count
    import cer_pkg::*;
#(
    parameter int ECNT_W = CER_ECNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ECNT_W-1:0] field,
    input  proto_e            proto,
    input  char_ev_t          rx_ev,
    output logic              rx_flag
);

    logic [ECNT_W-1:0] bad_cnt;
    logic              at_limit;

    assign at_limit = (bad_cnt == field);
    assign rx_flag  = rx_ev.done && rx_ev.bad && ((proto == PROTO_T1) || at_limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_cnt <= '0;
        end else if (rx_ev.done && proto == PROTO_T0) begin
            if (!rx_ev.bad || at_limit) begin
                bad_cnt <= '0;
            end else begin
                bad_cnt <= bad_cnt + 1'b1;
            end
        end
    end

    // R2: a good T=0 character leaves the count at zero
    a_r2_good_clears: assert property (@(posedge clk) disable iff (rst)
        rx_ev.done && !rx_ev.bad && proto == PROTO_T0 |=> bad_cnt == '0);

endmodule

// File: rtl/cer_tx_retry.sv
module cer_tx_retry
    import cer_pkg::*;
#(
    parameter int ECNT_W     = CER_ECNT_W,
    parameter int GUARD_HALF = CER_GUARD_HALF,
    parameter int RETX_HALF  = CER_RETX_HALF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ECNT_W-1:0] field,
    input  proto_e            proto,
    input  logic              half_tick,
    input  logic              tx_sof,
    input  char_ev_t          tx_ev,
    output logic              tx_flag,
    output logic              retx_go,
    output logic              tx_ready
);

    localparam int GAP_W = $clog2(RETX_HALF + 1);
    localparam logic [GAP_W-1:0] GUARD_L = GAP_W'(GUARD_HALF);
    localparam logic [GAP_W-1:0] RETX_L  = GAP_W'(RETX_HALF);
    localparam logic [GAP_W-1:0] PRE_L   = GAP_W'(RETX_HALF - 1);

    logic [GAP_W-1:0]  gap;
    logic              pending;
    logic [ECNT_W-1:0] used;
    logic              nak_ev;
    logic              ack_ev;
    logic              can_retry;
    logic              go_now;

    assign nak_ev    = tx_ev.done && tx_ev.bad && proto == PROTO_T0;
    assign ack_ev    = tx_ev.done && !tx_ev.bad && proto == PROTO_T0;
    assign can_retry = budget_left(used, field);
    assign tx_flag   = nak_ev && !can_retry;
    assign go_now    = pending && !tx_sof &&
                       ((half_tick && gap == PRE_L) || gap == RETX_L);
    assign tx_ready  = (gap >= GUARD_L) && !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap     <= RETX_L;
            pending <= 1'b0;
            used    <= '0;
            retx_go <= 1'b0;
        end else begin
            retx_go <= go_now;
            if (tx_sof) begin
                gap <= '0;
            end else if (half_tick && gap != RETX_L) begin
                gap <= gap + 1'b1;
            end
            if (go_now) begin
                pending <= 1'b0;
            end
            if (nak_ev) begin
                if (can_retry) begin
                    pending <= 1'b1;
                    used    <= used + 1'b1;
                end else begin
                    used <= '0;
                end
            end else if (ack_ev) begin
                used <= '0;
            end
        end
    end

    // R8: a resend pulse only ever appears at the 15 ETU point
    a_r8_go_at_retx_point: assert property (@(posedge clk) disable iff (rst)
        retx_go |-> gap == RETX_L);

    // R7: a resend is only scheduled when a budget has been programmed
    a_r7_pending_needs_budget: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(field) != '0);

    // R9: the line is never offered while a resend is outstanding
    a_r9_no_ready_while_pending: assert property (@(posedge clk) disable iff (rst)
        pending |-> !tx_ready);

endmodule

// File: rtl/cer_status.sv
module cer_status (
    input  logic clk,
    input  logic rst,
    input  logic err_ev,
    input  logic rd,
    output logic pe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pe <= 1'b0;
        end else if (err_ev) begin
            pe <= 1'b1;
        end else if (rd) begin
            pe <= 1'b0;
        end
    end

    // R3: an error event is visible in the next cycle
    a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
        err_ev |=> pe);

    // R4: a read with no new event clears the bit
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd && !err_ev |=> !pe);

    // R4: the bit only rises on an event
    a_r4_rise_needs_event: assert property (@(posedge clk) disable iff (rst)
        $rose(pe) |-> $past(err_ev));

endmodule

// File: rtl/card_err_retry.sv
module card_err_retry
    import cer_pkg::*;
#(
    parameter int REG_W      = CER_REG_W,
    parameter int ECNT_W     = CER_ECNT_W,
    parameter int GUARD_HALF = CER_GUARD_HALF,
    parameter int RETX_HALF  = CER_RETX_HALF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_etu_tick,
    input  logic             proto_t1,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             stat_rd,
    output logic [REG_W-1:0] stat_rdata,
    input  logic             rx_done,
    input  logic             rx_par_ok,
    input  logic             tx_sof,
    input  logic             tx_done,
    input  logic             tx_nak,
    output logic             retx_go,
    output logic             tx_ready,
    output logic             irq_n
);

    logic [ECNT_W-1:0] field;
    logic              ctrl_unused;
    proto_e            proto;
    char_ev_t          rx_ev;
    char_ev_t          tx_ev;
    logic              rx_flag;
    logic              tx_flag;
    logic              pe;

    assign ctrl_unused = ^ctrl_wdata[REG_W-1:ECNT_W];
    assign proto       = proto_e'(proto_t1);
    assign rx_ev       = '{done: rx_done, bad: !rx_par_ok};
    assign tx_ev       = '{done: tx_done, bad: tx_nak};

    always_ff @(posedge clk) begin
        if (rst) begin
            field <= '0;
        end else if (ctrl_wr) begin
            field <= ctrl_wdata[ECNT_W-1:0];
        end
    end

    cer_rx_count #(.ECNT_W(ECNT_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .field   (field),
        .proto   (proto),
        .rx_ev   (rx_ev),
        .rx_flag (rx_flag)
    );

    cer_tx_retry #(
        .ECNT_W     (ECNT_W),
        .GUARD_HALF (GUARD_HALF),
        .RETX_HALF  (RETX_HALF)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .field     (field),
        .proto     (proto),
        .half_tick (half_etu_tick),
        .tx_sof    (tx_sof),
        .tx_ev     (tx_ev),
        .tx_flag   (tx_flag),
        .retx_go   (retx_go),
        .tx_ready  (tx_ready)
    );

    cer_status u_st (
        .clk    (clk),
        .rst    (rst),
        .err_ev (rx_flag || tx_flag),
        .rd     (stat_rd),
        .pe     (pe)
    );

    assign stat_rdata = {{(REG_W-1){1'b0}}, pe};
    assign irq_n      = !pe;

    // R6: in T=1 the first bad character raises the status bit
    a_r6_t1_first_bad: assert property (@(posedge clk) disable iff (rst)
        rx_done && !rx_par_ok && proto_t1 |=> stat_rdata[0]);

    // R6: in T=1 a refusal never produces a resend
    a_r6_t1_no_resend: assert property (@(posedge clk) disable iff (rst)
        tx_done && tx_nak && proto_t1 |=> !retx_go);

    // R11: upper status bits stay zero
    a_r11_status_upper_zero: assert property (@(posedge clk) disable iff (rst)
        stat_rdata[REG_W-1:1] == '0);

endmodule

// File: tb/sim_card_err_retry.sv
`timescale 1ns/1ps
module sim_card_err_retry;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_etu_tick = 1'b0;
    logic       proto_t1 = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       rx_done = 1'b0;
    logic       rx_par_ok = 1'b0;
    logic       tx_sof = 1'b0;
    logic       tx_done = 1'b0;
    logic       tx_nak = 1'b0;
    logic       retx_go;
    logic       tx_ready;
    logic       irq_n;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    card_err_retry u0 (
        .clk(clk), .rst(rst), .half_etu_tick(half_etu_tick), .proto_t1(proto_t1),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .stat_rd(stat_rd),
        .stat_rdata(stat_rdata), .rx_done(rx_done), .rx_par_ok(rx_par_ok),
        .tx_sof(tx_sof), .tx_done(tx_done), .tx_nak(tx_nak), .retx_go(retx_go),
        .tx_ready(tx_ready), .irq_n(irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; proto_t1 = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = d;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic rx_char(input logic ok);
        @(negedge clk); rx_done = 1'b1; rx_par_ok = ok;
        @(negedge clk); rx_done = 1'b0;
    endtask

    task automatic tx_start();
        @(negedge clk); tx_sof = 1'b1;
        @(negedge clk); tx_sof = 1'b0;
    endtask

    task automatic tx_result(input logic nak);
        @(negedge clk); tx_done = 1'b1; tx_nak = nak;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic read_status(output logic [7:0] d);
        @(negedge clk); stat_rd = 1'b1; #1 d = stat_rdata;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    // n half-ETU ticks; counts retx_go pulses and the tick after which the first came
    task automatic ticks(input int n, output int gos, output int first);
        gos = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk); half_etu_tick = 1'b1;
            @(negedge clk); half_etu_tick = 1'b0;
            if (retx_go) begin
                gos++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 status bit", stat_rdata[0], 0);
        check("R10 irq_n", irq_n, 1);
        check("R10 tx_ready", tx_ready, 1);
        check("R10 retx_go", retx_go, 0);
        rx_char(1'b0);   // field is 0 after reset: one bad flags
        check("R10 field zero after reset", stat_rdata[0], 1);
    endtask

    task automatic t_threshold();
        logic [7:0] d;
        do_reset(); wr_ctrl(8'h02);
        rx_char(1'b0); rx_char(1'b0);
        check("R1 below limit F=2", stat_rdata[0], 0);
        rx_char(1'b0);
        check("R1 limit F=2", stat_rdata[0], 1);
        check("R3 irq_n low", irq_n, 0);
        read_status(d);
        check("R4 read data bit0", d[0], 1);
        check("R4 cleared after read", stat_rdata[0], 0);
        check("R4 irq released", irq_n, 1);
        rx_char(1'b0); rx_char(1'b0);
        check("R1 count restarted", stat_rdata[0], 0);
        wr_ctrl(8'h07);
        rx_char(1'b1);
        for (int i = 0; i < 7; i++) rx_char(1'b0);
        check("R1 seven bad F=7", stat_rdata[0], 0);
        rx_char(1'b0);
        check("R1 eighth bad F=7", stat_rdata[0], 1);
    endtask

    task automatic t_good_clears();
        do_reset(); wr_ctrl(8'h01);
        rx_char(1'b0); rx_char(1'b1); rx_char(1'b0);
        check("R2 good resets count", stat_rdata[0], 0);
        rx_char(1'b0);
        check("R2 two consecutive bad", stat_rdata[0], 1);
        rx_char(1'b1); rx_char(1'b1);
        tx_start(); tx_result(1'b0);
        check("R4 sticky without read", stat_rdata[0], 1);
        check("R4 irq stays low", irq_n, 0);
    endtask

    task automatic t_read_collide();
        do_reset(); wr_ctrl(8'h00);
        rx_char(1'b0);
        @(negedge clk); stat_rd = 1'b1; rx_done = 1'b1; rx_par_ok = 1'b0;
        @(negedge clk); stat_rd = 1'b0; rx_done = 1'b0;
        check("R5 bit kept on collision", stat_rdata[0], 1);
        check("R5 irq kept low", irq_n, 0);
    endtask

    task automatic t_t1();
        int g, f;
        do_reset(); wr_ctrl(8'h07); proto_t1 = 1'b1;
        rx_char(1'b0);
        check("R6 T1 first bad", stat_rdata[0], 1);
        do_reset(); wr_ctrl(8'h03); proto_t1 = 1'b1;
        tx_start(); tx_result(1'b1);
        check("R6 T1 nak no status", stat_rdata[0], 0);
        ticks(30, g, f);
        check("R6 T1 nak no resend", g, 0);
        check("R6 T1 line ready", tx_ready, 1);
    endtask

    task automatic t_retry();
        int g, f;
        do_reset(); wr_ctrl(8'h02);
        tx_start(); tx_result(1'b1);
        check("R7 resend pending blocks ready", tx_ready, 0);
        ticks(29, g, f);
        check("R8 no pulse before 30 ticks", g, 0);
        ticks(1, g, f);
        check("R8 pulse after 30th tick", g, 1);
        tx_start(); tx_result(1'b1);
        ticks(30, g, f);
        check("R7 second resend", g, 1);
        check("R8 second resend tick", f, 30);
        tx_start(); tx_result(1'b1);
        check("R7 budget used sets status", stat_rdata[0], 1);
        ticks(30, g, f);
        check("R7 no resend after budget", g, 0);
        do_reset(); wr_ctrl(8'h01);
        tx_start(); tx_result(1'b1);
        ticks(30, g, f);
        check("R7 F=1 resend", g, 1);
        tx_start(); tx_result(1'b0);
        tx_start(); tx_result(1'b1);
        ticks(30, g, f);
        check("R7 ack restores budget", g, 1);
        check("R7 no status after ack", stat_rdata[0], 0);
    endtask

    task automatic t_disabled();
        int g, f;
        do_reset(); wr_ctrl(8'hF8);   // upper bits set, field 0
        tx_start(); tx_result(1'b1);
        check("R9 nak with F=0 sets status", stat_rdata[0], 1);
        check("R11 upper status bits", int'(stat_rdata[7:1]), 0);
        ticks(26, g, f);
        check("R9 not ready at 26 ticks", tx_ready, 0);
        ticks(1, g, f);
        check("R9 ready at 27 ticks", tx_ready, 1);
        ticks(3, g, f);
        check("R9 no resend with F=0", g, 0);
        do_reset(); wr_ctrl(8'hF9);   // upper bits set, field 1
        rx_char(1'b0);
        check("R11 upper ctrl bits ignored", stat_rdata[0], 0);
        rx_char(1'b0);
        check("R11 field from bits 2:0", stat_rdata[0], 1);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_good_clears();
        t_read_collide();
        t_t1();
        t_retry();
        t_disabled();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule